// File: doc/BRIEF.md
# Three-Port Programmable Parallel I/O Block

This block gives a host bus access to three 8-bit parallel ports, called A, B and C, plus one control register. The bus side uses an active-low chip select, active-low read and write strobes, a 2-bit register address, and a data bus that is split into an input bus and an output bus with an output enable. Each port pin group has three vectors: an input vector, an output vector and an output-enable vector. Only the simple mode is implemented. In that mode a port either drives a latched value or passes its live pins back to the bus.

Port C is split into two 4-bit halves, and each half has its own direction. The upper half is paired with port A, and the lower half is paired with port B. A mode word written at address 3 sets the directions. Any word that asks for a handshaked or bidirectional mode is refused and raises an error flag. A word with bit 7 clear would be a single-bit operation on port C, so it is ignored.

Writes take effect on the rising clock edge while chip select and write are both low. Reads are combinational while chip select and read are both low.

Top module: `ppi_top`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 8'h9B, meaning every port and both halves of C are inputs. All output enables and output vectors are 0, and `mode_err` is 0.
- R2: `bus_oe` is 1 only while `cs_n` and `rd_n` are both 0. At all other times `bus_oe` is 0 and `bus_dout` is 8'h00.
- R3: The address selects the register as follows: 0 is port A, 1 is port B, 2 is port C and 3 is the control register. This applies to both reads and writes.
- R4: A write to a port, or a port-C half, that is set as output appears on that pin group's output vector after the write edge. Its output enables are then all 1.
- R5: Reading a port that is set as output returns its latch. Reading a port that is set as input returns its live input pins. The output vector of an input port is 0 and its enables are 0.
- R6: Control bit 3 sets the direction of C[7:4] and bit 0 sets the direction of C[3:0], with 1 meaning input. The two halves act independently of each other. Bit 4 sets the direction of port A and bit 1 sets the direction of port B.
- R7: An accepted mode word sets all port latches to 0.
- R8: A word with bit 7 = 1 and a nonzero value in bits 6:5 or bit 2 is refused. It sets `mode_err` and leaves the configuration and the latches unchanged. The next accepted word clears `mode_err`.
- R9: A control write with bit 7 = 0 changes nothing: not the configuration, not the latches and not `mode_err`.
- R10: While `cs_n` is 1, strobes have no effect on any register.
- R11: Reading address 3 returns the last accepted mode word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select |
| bus_din | input | 8 | Write data from host |
| bus_dout | output | 8 | Read data to host |
| bus_oe | output | 1 | Host bus drive enable |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A pins out |
| pa_oe | output | 8 | Port A drive enables |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B pins out |
| pb_oe | output | 8 | Port B drive enables |
| pc_in | input | 8 | Port C pins in |
| pc_out | output | 8 | Port C pins out |
| pc_oe | output | 8 | Port C drive enables |
| mode_err | output | 1 | Last mode-set word was refused |

## Verification
A wrong direction bit shows at the pins in the cycle after the control write. It appears as enables in the wrong state, or as a port read that returns the latch where the live pins were expected, or the reverse. Latch corruption, whether from a missed clear, a write through a deselected strobe or a write to the wrong address, only becomes visible when the affected port is read back as an output or drives its pins. For that reason the bench reads back every register and checks every pin group after each random operation. A flag or configuration that changes when it should not is caught on the next control read or `mode_err` sample.

// File: rtl/ppi_pkg.sv
// Package: shared register selects and control-word helpers for the
// three-port parallel block. Assumes an 8-bit control word.
package ppi_pkg;
    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    localparam logic [7:0] CTRL_RESET = 8'h9B;

    // Direction bit positions inside the control word (1 = input)
    localparam int DIR_A_BIT  = 4;
    localparam int DIR_CU_BIT = 3;
    localparam int DIR_B_BIT  = 1;
    localparam int DIR_CL_BIT = 0;

    // True when a mode-set word asks only for the simple mode
    function automatic logic simple_mode_ok(input logic [7:0] w);
        return (w[6:5] == 2'b00) && !w[2];
    endfunction
endpackage

// File: rtl/ppi_decode.sv
// Module: turns the host strobes and address into one-cycle register
// write enables and a read enable. Assumes the strobes are synchronous to clk.
module ppi_decode
    import ppi_pkg::*;
(
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [1:0] addr,
    output logic       wr_a,
    output logic       wr_b,
    output logic       wr_c,
    output logic       wr_ctrl,
    output logic       rd_en
);
    logic wr_any;

    // Qualify the strobes with chip select
    always_comb begin
        wr_any  = !cs_n && !wr_n;
        rd_en   = !cs_n && !rd_n;
        wr_a    = wr_any && (addr == SEL_A);
        wr_b    = wr_any && (addr == SEL_B);
        wr_c    = wr_any && (addr == SEL_C);
        wr_ctrl = wr_any && (addr == SEL_CTRL);
    end
endmodule

// File: rtl/ppi_ctrl.sv
// Module: holds the mode word and the refused-mode flag. Accepted words
// produce a load pulse that clears the port latches. Assumes that a write
// with bit 7 clear is a single-bit port-C request and ignores it.
module ppi_ctrl
    import ppi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic [7:0] din,
    output logic [7:0] ctrl_q,
    output logic       load,
    output logic       err_q
);
    logic is_set;
    logic supported;

    // Classify the incoming control write
    always_comb begin
        is_set    = wr_ctrl && din[7];
        supported = simple_mode_ok(din);
        load      = is_set && supported;
    end

    // Update the mode word and the error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            err_q  <= 1'b0;
        end else if (load) begin
            ctrl_q <= din;
            err_q  <= 1'b0;
        end else if (is_set) begin
            err_q  <= 1'b1;
        end
    end

    assert_reset_word_R1: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == CTRL_RESET) && !err_q);

    assert_refused_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_set && !supported) |=> $stable(ctrl_q) && err_q);

    assert_bit7_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !din[7]) |=> $stable(ctrl_q) && $stable(err_q));

    assert_accept_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ctrl_q == $past(din)) && !err_q);
endmodule

// File: rtl/ppi_slice.sv
// Module: one port pin group of width W. It holds an output latch, drives
// the pins only when set as output, and returns the latch or the pins for a
// read. Assumes clr and wr never fire together (they decode different addresses).
module ppi_slice #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic         clr,
    input  logic [W-1:0] din,
    input  logic         dir_in,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] rd_val
);
    logic [W-1:0] latch_q;

    // Output latch: cleared by reset or mode load, loaded by port write
    always_ff @(posedge clk) begin
        if (!rst_n)   latch_q <= '0;
        else if (clr) latch_q <= '0;
        else if (wr)  latch_q <= din;
    end

    // Pin drive and read-back selection by direction
    always_comb begin
        pin_oe  = dir_in ? '0 : '1;
        pin_out = dir_in ? '0 : latch_q;
        rd_val  = dir_in ? pin_in : latch_q;
    end

    assert_clear_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (latch_q == '0));

    assert_write_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr && !dir_in) |=> (pin_out == $past(din)) || $changed(dir_in));
endmodule

// File: rtl/ppi_top.sv
// Module: top of the three-port parallel block, simple mode only. Ports A
// and B are single byte slices. Port C is built as two half slices, each
// with its own direction bit. Assumes a synchronous host bus: writes commit
// on the clock edge and reads are combinational.
module ppi_top
    import ppi_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] bus_din,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe,
    output logic          mode_err
);
    localparam int HALF = DW / 2;

    logic wr_a, wr_b, wr_c, wr_ctrl, rd_en, load;
    logic [7:0]    ctrl_q;
    logic [DW-1:0] rd_a, rd_b, rd_c;

    ppi_decode u_dec (
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .wr_ctrl(wr_ctrl), .rd_en(rd_en)
    );

    ppi_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .din(bus_din[7:0]),
        .ctrl_q(ctrl_q), .load(load), .err_q(mode_err)
    );

    ppi_slice #(.W(DW)) u_pa (
        .clk(clk), .rst_n(rst_n), .wr(wr_a), .clr(load), .din(bus_din),
        .dir_in(ctrl_q[DIR_A_BIT]), .pin_in(pa_in),
        .pin_out(pa_out), .pin_oe(pa_oe), .rd_val(rd_a)
    );

    ppi_slice #(.W(DW)) u_pb (
        .clk(clk), .rst_n(rst_n), .wr(wr_b), .clr(load), .din(bus_din),
        .dir_in(ctrl_q[DIR_B_BIT]), .pin_in(pb_in),
        .pin_out(pb_out), .pin_oe(pb_oe), .rd_val(rd_b)
    );

    // Port C halves: index 0 is the lower half, index 1 the upper half
    for (genvar gi = 0; gi < 2; gi++) begin : g_pc
        localparam int DBIT = (gi == 0) ? DIR_CL_BIT : DIR_CU_BIT;
        ppi_slice #(.W(HALF)) u_half (
            .clk(clk), .rst_n(rst_n), .wr(wr_c), .clr(load),
            .din(bus_din[gi*HALF +: HALF]),
            .dir_in(ctrl_q[DBIT]), .pin_in(pc_in[gi*HALF +: HALF]),
            .pin_out(pc_out[gi*HALF +: HALF]), .pin_oe(pc_oe[gi*HALF +: HALF]),
            .rd_val(rd_c[gi*HALF +: HALF])
        );
    end

    // Read-back mux, quiet when not selected for read
    always_comb begin
        bus_oe   = rd_en;
        bus_dout = '0;
        if (rd_en) begin
            unique case (addr)
                SEL_A:    bus_dout = rd_a;
                SEL_B:    bus_dout = rd_b;
                SEL_C:    bus_dout = rd_c;
                default:  bus_dout = DW'(ctrl_q);
            endcase
        end
    end

    assert_bus_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (!bus_oe && bus_dout == '0));

    assert_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> $stable(ctrl_q) && $stable(mode_err) && $stable(pa_out)
                 && $stable(pb_out) && $stable(pc_out));

    assert_half_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pc_oe[HALF-1:0]) == 0 || $countones(pc_oe[HALF-1:0]) == HALF));
endmodule

// File: tb/sim_ppi_top.sv
module sim_ppi_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout, pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic bus_oe, mode_err;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [7:0] m_ctrl = 8'h9B, m_la = 0, m_lb = 0, m_lc = 0;
    logic m_err = 1'b0;

    always #2 clk = ~clk;

    ppi_top u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe), .mode_err(mode_err)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] sel(input logic d, input logic [7:0] pin, input logic [7:0] lat);
        return d ? pin : lat;
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return sel(m_ctrl[4], pa_in, m_la);
            2'd1: return sel(m_ctrl[1], pb_in, m_lb);
            2'd2: return {sel(m_ctrl[3], pc_in, m_lc)[7:4], sel(m_ctrl[0], pc_in, m_lc)[3:0]};
            default: return m_ctrl;
        endcase
    endfunction

    function automatic logic [7:0] exp_oe(input logic [1:0] a);
        case (a)
            2'd0: return m_ctrl[4] ? 8'h00 : 8'hFF;
            2'd1: return m_ctrl[1] ? 8'h00 : 8'hFF;
            default: return {m_ctrl[3] ? 4'h0 : 4'hF, m_ctrl[0] ? 4'h0 : 4'hF};
        endcase
    endfunction

    // Update the model for a selected write
    function automatic void model_write(input logic [1:0] a, input logic [7:0] d);
        case (a)
            2'd0: m_la = d;
            2'd1: m_lb = d;
            2'd2: m_lc = d;
            default: if (d[7]) begin
                if (d[6:5] == 0 && !d[2]) begin
                    m_ctrl = d; m_la = 0; m_lb = 0; m_lc = 0; m_err = 0;
                end else m_err = 1;
            end
        endcase
    endfunction

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
        @(negedge clk);
        cs_n = sel_n; wr_n = 1'b0; addr = a; bus_din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        if (!sel_n) model_write(a, d);
    endtask

    task automatic bus_read(input logic [1:0] a, input string tag);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1;
        check({tag, " R3 R5 read"}, bus_dout, exp_read(a));
        check({tag, " R2 oe"}, {7'd0, bus_oe}, 8'd1);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        #1;
        check({tag, " R2 quiet"}, {bus_oe, 7'd0} | bus_dout, 8'd0);
    endtask

    task automatic check_pins(input string tag);
        #1;
        check({tag, " R4 pa_oe"}, pa_oe, exp_oe(0));
        check({tag, " R4 pb_oe"}, pb_oe, exp_oe(1));
        check({tag, " R6 pc_oe"}, pc_oe, exp_oe(2));
        check({tag, " R4 pa_out"}, pa_out, m_la & exp_oe(0));
        check({tag, " R4 pb_out"}, pb_out, m_lb & exp_oe(1));
        check({tag, " R6 pc_out"}, pc_out, m_lc & exp_oe(2));
        check({tag, " R8 mode_err"}, {7'd0, mode_err}, {7'd0, m_err});
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 4; a++) bus_read(a[1:0], tag);
        check_pins(tag);
    endtask

    initial begin
        int r;
        r = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check_pins("R1 reset");
        bus_read(2'd3, "R1 R11 ctrl");
        pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h96;
        read_all("R5 inputs");
        // R4 R7: all outputs, then write each port
        bus_write(2'd3, 8'h80, 1'b0);
        bus_write(2'd0, 8'hA5, 1'b0);
        bus_write(2'd1, 8'h3C, 1'b0);
        bus_write(2'd2, 8'hE7, 1'b0);
        read_all("R4 outputs");
        // R6: upper C input, lower C output
        bus_write(2'd3, 8'h88, 1'b0);
        bus_write(2'd2, 8'h5F, 1'b0);
        read_all("R6 split upper");
        bus_write(2'd3, 8'h81, 1'b0);
        bus_write(2'd2, 8'hF5, 1'b0);
        read_all("R6 split lower");
        // R8: refused word keeps latches and config
        bus_write(2'd3, 8'hA0, 1'b0);
        read_all("R8 refused");
        bus_write(2'd3, 8'h84, 1'b0);
        read_all("R8 refused b2");
        // R9: bit 7 clear ignored
        bus_write(2'd3, 8'h0F, 1'b0);
        read_all("R9 ignored");
        // R7 R8: accepted word clears flag and latches
        bus_write(2'd3, 8'h80, 1'b0);
        read_all("R7 clear");
        // R10: deselected writes
        bus_write(2'd0, 8'hFF, 1'b1);
        bus_write(2'd3, 8'h9B, 1'b1);
        read_all("R10 deselect");
        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op = $urandom_range(0, 5);
            logic [7:0] d = 8'($urandom);
            pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
            case (op)
                0, 1: bus_write(2'($urandom_range(0, 2)), d, 1'b0);
                2: bus_write(2'd3, {1'b1, 2'b00, d[4:3], 1'b0, d[1:0]}, 1'b0);
                3: bus_write(2'd3, {1'b1, d[6:0] | 7'h04}, 1'b0);
                4: bus_write(2'd3, {1'b0, d[6:0]}, 1'b0);
                default: bus_write(2'($urandom_range(0, 3)), d, 1'b1);
            endcase
            read_all("R3 R11 random");
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule